// File: doc/BRIEF.md
# Serial Switch Command and Status Front End

This block is the digital control path of an eight-channel low-side switch controller. A host talks to it over a four-wire serial link: while chip select is held low, the host clocks an eight-bit command in on the data-in pin and reads an eight-bit status word back on the data-out pin. All serial pins are sampled in one system-clock domain. Clock and select edges are found from the synchronized samples, so the system clock must run at least eight times faster than the serial clock.

The command reaches the channel enables only when the frame was well formed. That means chip select rose after a nonzero multiple of eight falling serial-clock edges. Any other frame leaves the output latch unchanged. Channels 1 and 2 can also be switched by two active-low parallel pins, for PWM that does not depend on the serial link. A per-channel overload-off flag forces the matching enable low.

The frame engine is a two-state machine. FS_IDLE waits with data-out released. On the chip-select falling edge it moves to FS_FRAME and loads the status word. FS_FRAME shifts and counts clock edges. On the chip-select rising edge it goes back to FS_IDLE, and it commits the command only if the count is valid.

Top module: `serial_switch_ctl`

## Requirements
- R1: While chip select is low, each falling serial-clock edge shifts the data-in bit into the LSB of the 8-bit shift register, so the first bit sent ends in the MSB.
- R2: When chip select rises, the shift register is copied to the output latch only if the count of falling clock edges since chip select fell is 8, 16, 24 and so on. A count of 0, or any count that is not a multiple of 8, leaves the latch and the channel enables unchanged.
- R3: When chip select falls, the status word is parallel-loaded into the shift register and the edge count is cleared.
- R4: While a frame is open, `miso` presents the shift register MSB, and it moves to the next bit on each rising serial-clock edge after a falling edge. `miso_oe` is 1 only while chip select is low.
- R5: Command and status words share one bit layout. From bit 7 down to bit 0 it is channel 2, 4, 6, 8, 1, 3, 5, 7. In `stat_in`, `ovl_off` and `chan_en`, bit i belongs to channel i+1.
- R6: Channel 1 is on when `par_n[0]` is low or its command bit is 1. Channel 2 is on when `par_n[1]` is low or its command bit is 1. A parallel pin held high (its floating default) has no effect. Channels 3 to 8 follow their command bit only.
- R7: While `ovl_off[i]` is 1, `chan_en[i]` is 0, whatever the command bit or parallel pin says.
- R8: Reset is active when `arst_n` is low or `uv_flag` is high. It clears the latch and all registers, drives every `chan_en` bit to 0 and `miso_oe` to 0, and the channels stay off after reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | External asynchronous reset, active low |
| uv_flag | input | 1 | Supply undervoltage flag, resets while high |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| par_n | input | 2 | Active-low parallel on inputs for channels 1 and 2 |
| stat_in | input | 8 | Per-channel status bits, bit i = channel i+1 |
| ovl_off | input | 8 | Per-channel overload-off flags |
| chan_en | output | 8 | Channel enables, bit i = channel i+1 |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Data-out drive enable (0 = high impedance) |

## Verification
The bench sends all 256 command values and reads back a different status pattern in every frame. A wrong bit layout shows up as enables on the wrong channels or as a scrambled readback, and a design that shifts data-out on the wrong edge loses the first status bit. Frames of 0, 7 and 9 clocks must leave the enables untouched; a design that commits on any chip-select release would change them. A 16-clock frame must commit only its last eight bits. The bench also sweeps the parallel pins against set and cleared command bits and applies overload flags on top of commands that are on. It pulses the undervoltage flag to show that it resets the channels just as the reset pin does.

// File: rtl/serial_switch_pkg.sv
package serial_switch_pkg;

    typedef enum logic {
        FS_IDLE  = 1'b0,
        FS_FRAME = 1'b1
    } fstate_t;

    // Register position of channel index idx (0-based) in an n-bit word:
    // even channels (odd idx) fill the upper half, odd channels the lower.
    function automatic int unsigned reg_pos(input int unsigned idx, input int unsigned n);
        if (idx % 2 == 1)
            return n - 1 - (idx - 1) / 2;
        else
            return n / 2 - 1 - idx / 2;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            logic s1, s2, s3;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s1 <= RST_VAL[g];
                    s2 <= RST_VAL[g];
                    s3 <= RST_VAL[g];
                end else begin
                    s1 <= d[g];
                    s2 <= s1;
                    s3 <= s2;
                end
            end
            assign q[g]      = s2;
            assign q_prev[g] = s3;
        end
    endgenerate
endmodule

// File: rtl/frame_engine.sv
module frame_engine
    import serial_switch_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_s,
    input  logic         cs_p,
    input  logic         sck_s,
    input  logic         sck_p,
    input  logic         mosi_s,
    input  logic [N-1:0] stat_word,
    output logic [N-1:0] latch,
    output logic         miso,
    output logic         miso_oe
);
    localparam int unsigned CW = $clog2(N + 1);
    localparam logic [CW-1:0] FULL = CW'(N);

    fstate_t       state, nxt;
    logic [N-1:0]  sr;
    logic [CW-1:0] cnt;
    logic          miso_q;

    logic cs_fall, cs_rise, sck_fall, sck_rise;
    assign cs_fall  =  cs_p & ~cs_s;
    assign cs_rise  = ~cs_p &  cs_s;
    assign sck_fall =  sck_p & ~sck_s;
    assign sck_rise = ~sck_p &  sck_s;

    always_comb begin
        nxt = state;
        unique case (state)
            FS_IDLE:  if (cs_fall) nxt = FS_FRAME;
            FS_FRAME: if (cs_rise) nxt = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FS_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr     <= '0;
            cnt    <= '0;
            latch  <= '0;
            miso_q <= 1'b0;
        end else begin
            unique case (state)
                FS_IDLE: begin
                    if (cs_fall) begin
                        sr     <= stat_word;
                        cnt    <= '0;
                        miso_q <= stat_word[N-1];
                    end
                end
                FS_FRAME: begin
                    if (cs_rise) begin
                        if (cnt == FULL) latch <= sr;
                    end else begin
                        if (sck_fall) begin
                            sr  <= {sr[N-2:0], mosi_s};
                            cnt <= (cnt == FULL) ? CW'(1) : cnt + 1'b1;
                        end
                        if (sck_rise) miso_q <= sr[N-1];
                    end
                end
            endcase
        end
    end

    assign miso    = miso_q;
    assign miso_oe = (state == FS_FRAME);

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);

    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_FRAME && cs_rise && cnt != FULL) |=> $stable(latch));

    // R2
    commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_FRAME && cs_rise && cnt == FULL) |=> (latch == $past(sr)));

    // R3
    status_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_IDLE && cs_fall) |=> (sr == $past(stat_word) && cnt == '0));

    // R4
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_FRAME && cs_rise) |=> !miso_oe);
endmodule

// File: rtl/chan_mixer.sv
module chan_mixer
    import serial_switch_pkg::*;
#(
    parameter int unsigned N    = 8,
    parameter int unsigned NPAR = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    latch,
    input  logic [NPAR-1:0] par_n_s,
    input  logic [N-1:0]    ovl_off,
    output logic [N-1:0]    chan_en
);
    logic [N-1:0] want;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_ch
            localparam int unsigned P = reg_pos(g, N);
            if (g < NPAR) begin : g_par
                assign want[g] = latch[P] | ~par_n_s[g];
            end else begin : g_ser
                assign want[g] = latch[P];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_en <= '0;
        else        chan_en <= want & ~ovl_off;
    end

    // R7
    ovl_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ovl_off) |=> ((chan_en & $past(ovl_off)) == '0));

    // R6
    par_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_n_s[0] && !ovl_off[0]) |=> chan_en[0]);
endmodule

// File: rtl/serial_switch_ctl.sv
module serial_switch_ctl
    import serial_switch_pkg::*;
#(
    parameter int unsigned N    = 8,
    parameter int unsigned NPAR = 2
) (
    input  logic            clk,
    input  logic            arst_n,
    input  logic            uv_flag,
    input  logic            cs_n,
    input  logic            sck,
    input  logic            mosi,
    input  logic [NPAR-1:0] par_n,
    input  logic [N-1:0]    stat_in,
    input  logic [N-1:0]    ovl_off,
    output logic [N-1:0]    chan_en,
    output logic            miso,
    output logic            miso_oe
);
    localparam int unsigned SW = 3 + NPAR;
    localparam logic [SW-1:0] SRST = {{NPAR{1'b1}}, 1'b0, 1'b0, 1'b1};

    logic rst_n;
    assign rst_n = arst_n & ~uv_flag;

    logic [SW-1:0] s_q, s_p;
    pin_sync #(.W(SW), .RST_VAL(SRST)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      ({par_n, mosi, sck, cs_n}),
        .q      (s_q),
        .q_prev (s_p)
    );

    logic [N-1:0] stat_word;
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_map
            assign stat_word[reg_pos(g, N)] = stat_in[g];
        end
    endgenerate

    logic [N-1:0] latch;
    frame_engine #(.N(N)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (s_q[0]),
        .cs_p      (s_p[0]),
        .sck_s     (s_q[1]),
        .sck_p     (s_p[1]),
        .mosi_s    (s_q[2]),
        .stat_word (stat_word),
        .latch     (latch),
        .miso      (miso),
        .miso_oe   (miso_oe)
    );

    chan_mixer #(.N(N), .NPAR(NPAR)) u_mix (
        .clk     (clk),
        .rst_n   (rst_n),
        .latch   (latch),
        .par_n_s (s_q[SW-1:3]),
        .ovl_off (ovl_off),
        .chan_en (chan_en)
    );
endmodule

// File: tb/serial_switch_ctl_test.sv
module serial_switch_ctl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       arst_n = 1'b0, uv_flag = 1'b0;
    logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic [1:0] par_n = 2'b11;
    logic [7:0] stat_in = '0, ovl_off = '0;
    logic [7:0] chan_en;
    logic       miso, miso_oe;

    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_switch_ctl uut (
        .clk(clk), .arst_n(arst_n), .uv_flag(uv_flag), .cs_n(cs_n), .sck(sck),
        .mosi(mosi), .par_n(par_n), .stat_in(stat_in), .ovl_off(ovl_off),
        .chan_en(chan_en), .miso(miso), .miso_oe(miso_oe)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Register position of channel c (1-based): even channels high half, odd low half.
    function automatic int pos_of(input int c);
        return (c % 2 == 0) ? 8 - c / 2 : 3 - (c - 1) / 2;
    endfunction

    function automatic logic [7:0] to_reg(input logic [7:0] perch);
        logic [7:0] r = '0;
        for (int c = 1; c <= 8; c++) r[pos_of(c)] = perch[c-1];
        return r;
    endfunction

    function automatic logic [7:0] from_reg(input logic [7:0] r);
        logic [7:0] p = '0;
        for (int c = 1; c <= 8; c++) p[c-1] = r[pos_of(c)];
        return p;
    endfunction

    // Sends the low n bits of w, first bit = w[n-1]; returns the first 8 bits read.
    task automatic spi_xfer(input logic [15:0] w, input int n, output logic [7:0] rd, output logic oe_mid);
        rd = '0;
        cs_n = 1'b0;
        wait_clk(8);
        oe_mid = miso_oe;
        for (int k = 0; k < n; k++) begin
            mosi = w[n-1-k];
            wait_clk(4);
            sck = 1'b1;
            wait_clk(8);
            if (k < 8) rd = {rd[6:0], miso};
            sck = 1'b0;
            wait_clk(8);
        end
        wait_clk(2);
        cs_n = 1'b1;
        wait_clk(10);
    endtask

    logic       done = 1'b0;

    initial begin
        wait_clk(150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd, exp_en;
        logic oe;

        wait_clk(3);
        // R8 reset state
        chk(chan_en == 8'h00, "R8 reset enables", chan_en, 8'h00);
        chk(miso_oe == 1'b0, "R8 reset oe", miso_oe, 0);
        arst_n = 1'b1;
        wait_clk(5);

        // R1 R3 R4 R5: all command values, distinct status per frame
        for (int v = 0; v < 256; v++) begin
            stat_in = 8'(v) ^ 8'h5A;
            spi_xfer(16'(v), 8, rd, oe);
            exp_en = from_reg(8'(v));
            chk(chan_en == exp_en, "R1/R5 enables from command", chan_en, exp_en);
            chk(rd == to_reg(stat_in), "R3/R4/R5 status readback", rd, to_reg(stat_in));
            if (v % 64 == 0) begin
                chk(oe == 1'b1, "R4 oe in frame", oe, 1);
                chk(miso_oe == 1'b0, "R4 oe after frame", miso_oe, 0);
            end
        end

        // R2 invalid frame lengths keep the latch
        spi_xfer(16'h0000, 8, rd, oe);
        chk(chan_en == 8'h00, "R2 clear", chan_en, 0);
        spi_xfer(16'h007F, 7, rd, oe);
        chk(chan_en == 8'h00, "R2 seven clocks ignored", chan_en, 0);
        spi_xfer(16'h01FF, 9, rd, oe);
        chk(chan_en == 8'h00, "R2 nine clocks ignored", chan_en, 0);
        spi_xfer(16'h0000, 0, rd, oe);
        chk(chan_en == 8'h00, "R2 zero clocks ignored", chan_en, 0);
        spi_xfer(16'hFFC3, 16, rd, oe);
        chk(chan_en == from_reg(8'hC3), "R2 sixteen clocks commit last byte", chan_en, from_reg(8'hC3));
        spi_xfer(16'h003C, 15, rd, oe);
        chk(chan_en == from_reg(8'hC3), "R2 fifteen clocks ignored", chan_en, from_reg(8'hC3));

        // R6 parallel pins against command cleared and set
        spi_xfer(16'h0000, 8, rd, oe);
        for (int p = 0; p < 4; p++) begin
            par_n = 2'(p);
            wait_clk(8);
            exp_en = {6'b0, ~2'(p)};
            chk(chan_en == exp_en, "R6 parallel pins, command off", chan_en, exp_en);
        end
        par_n = 2'b11;
        spi_xfer(16'h0088, 8, rd, oe); // bit7 = ch2, bit3 = ch1
        chk(chan_en == 8'h03, "R6 serial bits ch1 ch2", chan_en, 8'h03);
        par_n = 2'b00;
        wait_clk(8);
        chk(chan_en == 8'h03, "R6 pin and bit both on", chan_en, 8'h03);
        par_n = 2'b11;
        spi_xfer(16'h0077, 8, rd, oe); // channels 3..8 only
        par_n = 2'b00;
        wait_clk(8);
        chk(chan_en == 8'hFF, "R6 pins add ch1 ch2 only", chan_en, 8'hFF);
        par_n = 2'b11;
        wait_clk(8);
        chk(chan_en == 8'hFC, "R6 pins released", chan_en, 8'hFC);

        // R7 overload forcing
        spi_xfer(16'h00FF, 8, rd, oe);
        ovl_off = 8'h81;
        wait_clk(3);
        chk(chan_en == 8'h7E, "R7 overload off", chan_en, 8'h7E);
        par_n = 2'b00;
        ovl_off = 8'h03;
        wait_clk(8);
        chk(chan_en == 8'hFC, "R7 overload beats parallel pin", chan_en, 8'hFC);
        par_n = 2'b11;
        ovl_off = 8'h00;
        wait_clk(8);
        chk(chan_en == 8'hFF, "R7 overload released", chan_en, 8'hFF);

        // R8 undervoltage and reset pin
        uv_flag = 1'b1;
        wait_clk(3);
        chk(chan_en == 8'h00, "R8 undervoltage off", chan_en, 0);
        uv_flag = 1'b0;
        wait_clk(8);
        chk(chan_en == 8'h00, "R8 stays off after undervoltage", chan_en, 0);
        spi_xfer(16'h00AA, 8, rd, oe);
        chk(chan_en == from_reg(8'hAA), "R8 command after undervoltage", chan_en, from_reg(8'hAA));
        arst_n = 1'b0;
        wait_clk(3);
        chk(chan_en == 8'h00 && miso_oe == 1'b0, "R8 reset pin", chan_en, 0);
        arst_n = 1'b1;
        wait_clk(8);
        chk(chan_en == 8'h00, "R8 stays off after reset pin", chan_en, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule